// File: doc/BRIEF.md
# Input-Adaptive Approximate Adder/Subtractor

This block is an 8-bit ripple-carry adder/subtractor for image-pipeline arithmetic. Each bit position is a dual-mode full-adder cell. A cell either computes an exact full-adder function or drops into a cheap pass-through approximation: its sum copies its B input, its carry-out copies its A input, and its carry-in is ignored. While a cell is approximating, its exact logic is flagged as idle. That flag stands in for power gating.

A small depth decoder looks at the operands of each operation. It picks how many low-order cells approximate, taking the position of the most significant set bit of the larger operand. Large operands tolerate error in their low bits, so they get a deeper approximation. Small operands are computed exactly. A quality-enable input forces exact operation when it is low. Subtraction inverts B at the cell inputs and injects a carry of one into bit 0, so the carry-out reads as an active-low borrow.

The result, carry, chosen depth and per-cell idle flags are registered. They appear one clock after the operands are presented.

Top module: `approx_addsub`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `sum_q`, `carry_q`, `level_q` and `exact_off_q` are all zero.
- R2: When the depth is 0, addition gives `{carry_q,sum_q}` equal to `op_a + op_b` as a 9-bit value, one cycle after the operands.
- R3: When the depth is 0 and `sub_en`=1, `sum_q` equals `(op_a - op_b) mod 256`. In that case `carry_q` is 1 exactly when `op_a >= op_b` (no borrow).
- R4: With `qual_en`=1, the depth reported on `level_q` depends on the highest set bit position p of `op_a | op_b`. The depth is 4 when p is 6 or 7, 2 when p is 4 or 5, and 0 otherwise (this includes both operands being zero).
- R5: With `qual_en`=0, the depth is 0 for every operand pair, so the result is exact.
- R6: For each approximated bit i (i < depth), `sum_q[i]` equals the B value the cell sees: `op_b[i]` for add and `~op_b[i]` for subtract.
- R7: For depth d > 0, bits d..7 are an exact sum of `op_a[7:d]`, the cell B inputs [7:d], and a carry-in equal to `op_a[d-1]`. The final carry of that sum appears on `carry_q`.
- R8: `exact_off_q[i]` is 1 exactly for the cells i < depth, marking their exact logic as idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 8 | Operand A |
| op_b | input | 8 | Operand B |
| sub_en | input | 1 | 1 selects A minus B, 0 selects A plus B |
| qual_en | input | 1 | 1 lets the decoder approximate, 0 forces exact |
| sum_q | output | 8 | Registered result |
| carry_q | output | 1 | Registered carry-out (active-low borrow when subtracting) |
| level_q | output | 4 | Registered number of approximated low bits |
| exact_off_q | output | 8 | Registered per-cell idle flag for the exact logic |

## Verification
With quality disabled, every operand pair is applied for both addition and subtraction. This pins the exact datapath, including carry and borrow at the wrap points, bit for bit against ideal arithmetic. With quality enabled, every A value is paired with a spread of B values. This crosses all three depth bands and both operand orders, separating the decoder mapping from the pass-through bits and from the carry handed from the top approximated cell to the first exact cell. Directed pairs sit on the band edges (bit 3 versus bit 4, bit 5 versus bit 6) and on all-zero operands.

// File: rtl/approx_pkg.sv
package approx_pkg;
    localparam int DATA_W  = 8;
    localparam int LEVEL_W = $clog2(DATA_W + 1);

    typedef struct packed {
        logic [DATA_W-1:0]  sum;
        logic               carry;
        logic [LEVEL_W-1:0] level;
        logic [DATA_W-1:0]  off;
    } result_t;
endpackage

// File: rtl/dual_mode_fa.sv
module dual_mode_fa (
    input  logic a,
    input  logic b,
    input  logic cin,
    input  logic app,
    output logic s,
    output logic cout,
    output logic exact_on
);
    logic s_exact, c_exact;

    always_comb begin
        s_exact  = a ^ b ^ cin;
        c_exact  = (a & b) | (cin & (a ^ b));
        // approximate mode: sum follows B, carry follows A, carry-in unused
        s        = app ? b : s_exact;
        cout     = app ? a : c_exact;
        exact_on = ~app;
    end
endmodule

// File: rtl/approx_depth_dec.sv
module approx_depth_dec #(
    parameter int WIDTH    = 8,
    parameter int TH_LO    = 4,
    parameter int TH_HI    = 6,
    parameter int DEPTH_LO = 2,
    parameter int DEPTH_HI = 4,
    localparam int LW      = $clog2(WIDTH + 1)
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             qual_en,
    output logic [LW-1:0]    depth
);
    logic [WIDTH-1:0] merged;
    logic             hit_lo, hit_hi;

    always_comb begin
        merged = op_a | op_b;
        hit_lo = 1'b0;
        hit_hi = 1'b0;
        for (int i = TH_LO; i < WIDTH; i++) begin
            if (merged[i]) begin
                if (i >= TH_HI) hit_hi = 1'b1;
                else            hit_lo = 1'b1;
            end
        end
        if (!qual_en)     depth = '0;
        else if (hit_hi)  depth = LW'(DEPTH_HI);
        else if (hit_lo)  depth = LW'(DEPTH_LO);
        else              depth = '0;
    end
endmodule

// File: rtl/approx_addsub.sv
module approx_addsub
    import approx_pkg::*;
#(
    parameter int TH_LO    = 4,
    parameter int TH_HI    = 6,
    parameter int DEPTH_LO = 2,
    parameter int DEPTH_HI = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DATA_W-1:0]  op_a,
    input  logic [DATA_W-1:0]  op_b,
    input  logic               sub_en,
    input  logic               qual_en,
    output logic [DATA_W-1:0]  sum_q,
    output logic               carry_q,
    output logic [LEVEL_W-1:0] level_q,
    output logic [DATA_W-1:0]  exact_off_q
);
    logic [LEVEL_W-1:0] depth_w;
    logic [DATA_W-1:0]  b_eff;
    logic [DATA_W:0]    chain;
    logic [DATA_W-1:0]  app_w, sum_w, exact_on_w;
    result_t            st_d, st_q;

    approx_depth_dec #(
        .WIDTH(DATA_W), .TH_LO(TH_LO), .TH_HI(TH_HI),
        .DEPTH_LO(DEPTH_LO), .DEPTH_HI(DEPTH_HI)
    ) u_dec (
        .op_a(op_a), .op_b(op_b), .qual_en(qual_en), .depth(depth_w)
    );

    assign b_eff    = sub_en ? ~op_b : op_b;
    assign chain[0] = sub_en;

    for (genvar i = 0; i < DATA_W; i++) begin : g_cell
        assign app_w[i] = (LEVEL_W'(i) < depth_w);
        dual_mode_fa u_fa (
            .a(op_a[i]), .b(b_eff[i]), .cin(chain[i]), .app(app_w[i]),
            .s(sum_w[i]), .cout(chain[i+1]), .exact_on(exact_on_w[i])
        );
    end

    always_comb begin
        st_d.sum   = sum_w;
        st_d.carry = chain[DATA_W];
        st_d.level = depth_w;
        st_d.off   = ~exact_on_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sum_q       = st_q.sum;
    assign carry_q     = st_q.carry;
    assign level_q     = st_q.level;
    assign exact_off_q = st_q.off;

    AST_EXACT_ARITH: assert property (@(posedge clk) disable iff (!rst_n)
        !qual_en |=> {carry_q, sum_q} ==
            $past({1'b0, op_a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub_en})); // R2
    AST_QUAL_OFF_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        !qual_en |=> level_q == '0); // R5
    AST_DEEP_BAND: assert property (@(posedge clk) disable iff (!rst_n)
        (qual_en && |((op_a | op_b) >> TH_HI)) |=> level_q == LEVEL_W'(DEPTH_HI)); // R4
    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (qual_en && |((op_a | op_b) >> TH_HI)) |=>
            sum_q[DEPTH_HI-1:0] == $past(b_eff[DEPTH_HI-1:0])); // R6
    AST_IDLE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        exact_off_q == ((DATA_W'(1) << level_q) - DATA_W'(1))); // R8
endmodule

// File: tb/approx_addsub_test.sv
module approx_addsub_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] op_a = '0, op_b = '0;
    logic       sub_en = 1'b0, qual_en = 1'b0;
    logic [7:0] sum_q, exact_off_q;
    logic       carry_q;
    logic [3:0] level_q;

    int checks = 0;
    int errors = 0;
    bit running = 1'b1;

    typedef struct {
        logic [7:0] sum;
        logic       carry;
        logic [3:0] level;
        logic [7:0] off;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #5 clk = ~clk;

    approx_addsub uut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .sub_en(sub_en), .qual_en(qual_en), .sum_q(sum_q),
        .carry_q(carry_q), .level_q(level_q), .exact_off_q(exact_off_q)
    );

    function automatic exp_t model(logic [7:0] a, logic [7:0] b, logic s, logic q);
        exp_t e;
        logic [7:0] be, msk, o;
        logic [8:0] s9, m9;
        int d;
        o  = a | b;
        d  = !q ? 0 : (|o[7:6]) ? 4 : (|o[5:4]) ? 2 : 0;
        be = s ? ~b : b;
        msk = 8'((9'd1 << d) - 9'd1);
        if (d == 0) begin
            s9 = {1'b0, a} + {1'b0, be} + {8'd0, s};
        end else begin
            m9 = ~{1'b0, msk};
            s9 = ({1'b0, a} & m9) + ({1'b0, be} & m9) + ({8'd0, a[d-1]} << d);
        end
        e.sum   = (s9[7:0] & ~msk) | (be & msk);
        e.carry = s9[8];
        e.level = 4'(d);
        e.off   = msk;
        if (!q)          e.tag = s ? "R3 R5" : "R2 R5";
        else if (d == 0) e.tag = s ? "R3 R4" : "R2 R4";
        else             e.tag = "R6 R7";
        return e;
    endfunction

    task automatic drive(logic [7:0] a, logic [7:0] b, logic s, logic q);
        @(negedge clk);
        op_a = a; op_b = b; sub_en = s; qual_en = q;
        sb.push_back(model(a, b, s, q));
    endtask

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            if (errors < 20)
                $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: one result per cycle, one clock after the operands
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(sum_q == e.sum,     e.tag, sum_q, e.sum);
            check(carry_q == e.carry, e.tag, carry_q, e.carry);
            check(level_q == e.level, "R4", level_q, e.level);
            check(exact_off_q == e.off, "R8", exact_off_q, e.off);
        end
    end

    initial begin
        for (int c = 0; c < 195000 && running; c++) @(posedge clk);
        if (running) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(sum_q == 0 && carry_q == 0 && level_q == 0 && exact_off_q == 0,
              "R1", {sum_q, carry_q, level_q, exact_off_q}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        check(sum_q == 0 && carry_q == 0 && level_q == 0 && exact_off_q == 0,
              "R1", {sum_q, carry_q, level_q, exact_off_q}, 0);
        // directed corners: band edges, wrap, borrow, zero operands
        drive(8'hFF, 8'h01, 1'b0, 1'b0);  // R2 carry-out
        drive(8'h00, 8'h01, 1'b1, 1'b0);  // R3 borrow
        drive(8'h0F, 8'h00, 1'b0, 1'b1);  // R4 bit 3 -> depth 0
        drive(8'h10, 8'h00, 1'b0, 1'b1);  // R4 bit 4 -> depth 2
        drive(8'h3F, 8'h01, 1'b1, 1'b1);  // R4 bit 5 -> depth 2
        drive(8'h40, 8'h0F, 1'b0, 1'b1);  // R4 bit 6 -> depth 4
        drive(8'h00, 8'h00, 1'b0, 1'b1);  // R4 zero operands
        drive(8'hC8, 8'h0B, 1'b1, 1'b1);  // R6 R7 subtract deep
        drive(8'hF0, 8'hF0, 1'b0, 1'b0);  // R5 large operands exact
        // exhaustive exact datapath, both operations (R2 R3 R5)
        for (int s = 0; s < 2; s++)
            for (int a = 0; a < 256; a++)
                for (int b = 0; b < 256; b++)
                    drive(8'(a), 8'(b), s[0], 1'b0);
        // adaptive sweep across all bands (R4 R6 R7 R8)
        for (int s = 0; s < 2; s++)
            for (int a = 0; a < 256; a++)
                for (int b = 0; b < 256; b += 7)
                    drive(8'(a), 8'(b), s[0], 1'b1);
        @(negedge clk);
        @(negedge clk);
        running = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule